// File: doc/BRIEF.md
# Triggered Capture Scope with Streamed Bus Readout

This block is an on-chip debug recorder. It writes a 32-bit probe word into a circular store of 2^LG_DEPTH entries on every clock. Once the store has been filled completely since the last restart, the scope is primed. It then waits for a trigger, which is either the external trigger input or a manual force bit. After the trigger it records a programmable number of further samples and then freezes, keeping a window around the event.

A host reaches the block through a small 32-bit slave with two word addresses. Address 0 is a control register on write and a status word on read. Address 1 is the data port. The host polls the status word until the stopped and triggered flags are both set. It then reads address 1 repeatedly, with no address increment. Each read returns the next stored sample, oldest first, and the readout wraps after 2^LG_DEPTH reads.

Top module: `capture_scope`

## Requirements
- R1: Status bit 31 reads 1 in the cycle after reset is released and in the cycle after any control write, and reads 0 from the following cycle on.
- R2: The status word carries these fields: bit 30 stopped, bit 29 triggered, bit 28 primed, bit 27 manual, bit 26 disabled, bit 25 set when the holdoff is zero, bits 24:20 equal to LG_DEPTH, and bits 19:0 the holdoff count. After reset all flags are clear, the holdoff is 0, and bit 25 is set.
- R3: Primed (bit 28) sets only after 2^LG_DEPTH samples have been written since the last restart. A trigger input pulse that arrives before then has no effect.
- R4: When primed, and not already triggered, a high trigger input with the disabled bit clear sets triggered. The sample taken in the trigger cycle is stored, exactly `holdoff` further samples are then stored, and stopped then sets. With a holdoff of 0, the newest stored word is the trigger sample.
- R5: A control write with bit 26 set makes the scope ignore the trigger input: triggered stays 0 while primed.
- R6: A control write with bit 27 set forces a trigger as soon as the scope is primed, with no trigger input.
- R7: Once stopped, each data-port read returns the next stored sample. The first read returns the oldest sample, and the read after 2^LG_DEPTH reads returns the oldest sample again.
- R8: A control write loads the holdoff from bits 19:0 and restarts the scope: it clears stopped, triggered and primed, and begins filling the store again.
- R9: Every strobed access is acknowledged exactly one cycle later, and back-to-back strobes are acknowledged on consecutive cycles with no stall. A write to the data port changes neither the stored samples nor the read position.
- R10: After stopping, no further samples are stored. A second full readout pass returns the same words as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = data port |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after the strobe |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| probe_in | input | 32 | Signals to record |
| trig_in | input | 1 | External trigger |

## Verification
The hardest state to reach is a frozen store whose exact contents can be predicted. Reaching it needs a full priming pass, a trigger landing on a known cycle, and the holdoff elapsing, all without seeing inside the design. The bench drives the probe with a free-running count. It records the count value present in the cycle where it raises the trigger, and from that value and the holdoff it derives every word the readout must return, including the wrap back to the oldest word. For the manual force, the trigger cycle is not visible at the ports. There the first word read anchors the expected run, and a second readout pass confirms the store stayed frozen.

// File: rtl/scope_pkg.sv
// Package: shared field positions, configuration type and status packing
// for the capture scope. Assumes a 32-bit bus word.
package scope_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HOLD_W = 20;

    // Status / control bit positions (host software decodes these)
    localparam int unsigned POS_CLEAR = 31;
    localparam int unsigned POS_STOP  = 30;
    localparam int unsigned POS_TRIG  = 29;
    localparam int unsigned POS_PRIME = 28;
    localparam int unsigned POS_MAN   = 27;
    localparam int unsigned POS_DIS   = 26;
    localparam int unsigned POS_ZERO  = 25;
    localparam int unsigned POS_LGLEN = 20;

    typedef struct packed {
        logic              manual;
        logic              disabled;
        logic [HOLD_W-1:0] holdoff;
    } scope_cfg_t;

    // Assemble the status word from flags, configuration and depth field
    function automatic logic [BUS_W-1:0] pack_status(
        input logic       clearing,
        input logic       stopped,
        input logic       triggered,
        input logic       primed,
        input scope_cfg_t cfg,
        input logic [4:0] lg_len
    );
        logic [BUS_W-1:0] w;
        w                          = '0;
        w[POS_CLEAR]               = clearing;
        w[POS_STOP]                = stopped;
        w[POS_TRIG]                = triggered;
        w[POS_PRIME]               = primed;
        w[POS_MAN]                 = cfg.manual;
        w[POS_DIS]                 = cfg.disabled;
        w[POS_ZERO]                = (cfg.holdoff == '0);
        w[POS_LGLEN+4:POS_LGLEN]   = lg_len;
        w[HOLD_W-1:0]              = cfg.holdoff;
        return w;
    endfunction

endpackage

// File: rtl/scope_cfg.sv
// Module: scope_cfg
// Holds the host-written configuration and produces the one-cycle clearing
// flag that restarts capture. Assumes wr_en is a single-cycle write strobe.
module scope_cfg
    import scope_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output scope_cfg_t       cfg,
    output logic             clearing
);

    logic wdata_unused;
    assign wdata_unused = ^{wdata[BUS_W-1:POS_MAN+1], wdata[POS_DIS-1:HOLD_W]};

    // Configuration register: loaded on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.manual   <= wdata[POS_MAN];
            cfg.disabled <= wdata[POS_DIS];
            cfg.holdoff  <= wdata[HOLD_W-1:0];
        end
    end

    // Clearing flag: high during reset and for one cycle after a write
    always_ff @(posedge clk) begin
        if (!rst_n) clearing <= 1'b1;
        else        clearing <= wr_en;
    end

    AST_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> clearing);                                    // R1
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && !wr_en) |=> !clearing);                    // R1

endmodule

// File: rtl/scope_capture.sv
// Module: scope_capture
// Capture sequencer: write pointer, priming count, trigger detection,
// post-trigger holdoff and the readout pointer. Assumes clearing is a
// synchronous restart and rd_adv pulses once per data-port read.
module scope_capture
    import scope_pkg::*;
#(
    parameter int unsigned LG_DEPTH = 5
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clearing,
    input  scope_cfg_t          cfg,
    input  logic                trig_in,
    input  logic                rd_adv,
    output logic                wr_en,
    output logic [LG_DEPTH-1:0] wr_ptr,
    output logic [LG_DEPTH-1:0] rd_ptr,
    output logic                primed,
    output logic                triggered,
    output logic                stopped
);

    localparam logic [LG_DEPTH-1:0] FILL_LAST = {LG_DEPTH{1'b1}};

    logic [LG_DEPTH-1:0] fill_cnt;
    logic [HOLD_W-1:0]   post_cnt;
    logic                hold_done;
    logic                fire;

    assign hold_done = triggered && (post_cnt == cfg.holdoff);
    assign wr_en     = !clearing && !stopped && !hold_done;
    assign fire      = primed && !triggered && !stopped &&
                       (cfg.manual || (trig_in && !cfg.disabled));

    // Write pointer and priming count: advance on each stored sample
    always_ff @(posedge clk) begin
        if (!rst_n || clearing) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
            primed   <= 1'b0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (!primed) begin
                fill_cnt <= fill_cnt + 1'b1;
                if (fill_cnt == FILL_LAST) primed <= 1'b1;
            end
        end
    end

    // Trigger and holdoff: latch trigger, count post samples, then stop
    always_ff @(posedge clk) begin
        if (!rst_n || clearing) begin
            triggered <= 1'b0;
            stopped   <= 1'b0;
            post_cnt  <= '0;
        end else begin
            if (fire) triggered <= 1'b1;
            if (triggered && !stopped) begin
                if (hold_done) stopped  <= 1'b1;
                else           post_cnt <= post_cnt + 1'b1;
            end
        end
    end

    // Readout pointer: follows the oldest entry, then steps on each read
    always_ff @(posedge clk) begin
        if (!rst_n || clearing)  rd_ptr <= '0;
        else if (!stopped)       rd_ptr <= wr_ptr;
        else if (rd_adv)         rd_ptr <= rd_ptr + 1'b1;
    end

    AST_STOP_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> triggered);                                 // R10
    AST_TRIG_NEEDS_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> primed);                           // R3
    AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !wr_en);                                    // R10
    AST_DISABLED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clearing && primed && !triggered && cfg.disabled && !cfg.manual)
        |=> !triggered);                                        // R5
    AST_MANUAL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clearing && primed && !triggered && !stopped && cfg.manual)
        |=> triggered);                                         // R6
    AST_READ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && rd_adv && !clearing) |=> (rd_ptr == $past(rd_ptr) + 1'b1)); // R7

endmodule

// File: rtl/scope_store.sv
// Module: scope_store
// Sample storage: one write port, one asynchronous read port.
// Assumes the reader registers the read word.
module scope_store #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned LG_DEPTH = 5
)(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [LG_DEPTH-1:0] wr_addr,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic [LG_DEPTH-1:0] rd_addr,
    output logic [WORD_W-1:0]   rd_word
);

    localparam int unsigned DEPTH = 1 << LG_DEPTH;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store the probe word at the write pointer
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/scope_bus.sv
// Module: scope_bus
// Slave decode: one-cycle acknowledge, registered read data, write and
// read strobes toward the configuration and readout logic. Never stalls.
module scope_bus
    import scope_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] status_word,
    input  logic [BUS_W-1:0] data_word,
    output logic             bus_ack,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             cfg_wr,
    output logic             data_rd
);

    logic access;
    assign access  = bus_cyc && bus_stb;
    assign cfg_wr  = access && bus_we && !bus_addr;
    assign data_rd = access && !bus_we && bus_addr;

    // Acknowledge every strobe on the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) bus_ack <= 1'b0;
        else        bus_ack <= access;
    end

    // Register the selected read word
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (access) bus_rdata <= bus_addr ? data_word : status_word;
    end

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> bus_ack);                                    // R9
    AST_ACK_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(access));                             // R9

endmodule

// File: rtl/capture_scope.sv
// Module: capture_scope (top)
// Triggered capture scope with a two-address bus slave. Records probe_in
// every cycle into a 2^LG_DEPTH circular store; freezes holdoff samples
// after a trigger; streams the store oldest-first from the data port.
module capture_scope
    import scope_pkg::*;
#(
    parameter int unsigned LG_DEPTH = 5
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cyc,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic [31:0] bus_rdata,
    input  logic [31:0] probe_in,
    input  logic        trig_in
);

    localparam logic [4:0] LG_FIELD = 5'(LG_DEPTH);

    scope_cfg_t          cfg;
    logic                clearing;
    logic                cfg_wr;
    logic                data_rd;
    logic                wr_en;
    logic [LG_DEPTH-1:0] wr_ptr;
    logic [LG_DEPTH-1:0] rd_ptr;
    logic                primed;
    logic                triggered;
    logic                stopped;
    logic [BUS_W-1:0]    data_word;
    logic [BUS_W-1:0]    status_word;

    assign status_word = pack_status(clearing, stopped, triggered, primed,
                                     cfg, LG_FIELD);

    scope_bus u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_cyc     (bus_cyc),
        .bus_stb     (bus_stb),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .status_word (status_word),
        .data_word   (data_word),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .cfg_wr      (cfg_wr),
        .data_rd     (data_rd)
    );

    scope_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wdata    (bus_wdata),
        .cfg      (cfg),
        .clearing (clearing)
    );

    scope_capture #(.LG_DEPTH(LG_DEPTH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clearing  (clearing),
        .cfg       (cfg),
        .trig_in   (trig_in),
        .rd_adv    (data_rd),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .primed    (primed),
        .triggered (triggered),
        .stopped   (stopped)
    );

    scope_store #(.WORD_W(BUS_W), .LG_DEPTH(LG_DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_word (probe_in),
        .rd_addr (rd_ptr),
        .rd_word (data_word)
    );

endmodule

// File: tb/capture_scope_tb.sv
// Scoreboard bench: driver tasks queue expected read words; a monitor pops
// and compares them when the acknowledge appears.
module capture_scope_tb;

    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_cyc, bus_stb, bus_we, bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [31:0] probe_in = '0;
    logic        trig_in;

    int errors = 0;
    int checks = 0;
    int cyc_cnt = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] val;
        logic [31:0] mask;
        int          due;
        string       tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    capture_scope #(.LG_DEPTH(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .probe_in(probe_in),
        .trig_in(trig_in)
    );

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;
    always @(negedge clk) probe_in <= probe_in + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each acknowledged word with the queued expectation
    always @(negedge clk) begin
        if (bus_ack) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected ack", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(((bus_rdata & it.mask) == (it.val & it.mask)) && (cyc_cnt == it.due),
                    it.tag, bus_rdata, it.val);
            end
        end
    end

    task automatic push(input logic [31:0] v, input logic [31:0] m, input string tag);
        item_t it;
        it.val = v; it.mask = m; it.due = cyc_cnt + 1; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic bus_rd(input logic a, input logic [31:0] v,
                          input logic [31:0] m, input string tag);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = a;
        push(v, m, tag);
        @(posedge clk);
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        push('0, '0, "R9 write ack");
        @(posedge clk);
    endtask

    task automatic bus_idle();
        @(negedge clk);
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Pulse the trigger for one cycle; return the probe value sampled then
    task automatic trig_pulse(output logic [31:0] v);
        @(negedge clk);
        trig_in = 1;
        @(posedge clk);
        v = probe_in;
        @(negedge clk);
        trig_in = 0;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] x;
        rst_n = 0; bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_addr = 0;
        bus_wdata = '0; trig_in = 0;
        repeat (4) @(negedge clk);
        chk(bus_ack == 1'b0, "R9 ack low in reset", {31'b0, bus_ack}, 32'h0);

        // Reset release with a status read in the same cycle
        @(negedge clk);
        rst_n = 1; bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = 0;
        push(32'h8250_0000, '1, "R1 clearing after reset");
        @(posedge clk);
        bus_rd(0, 32'h0250_0000, '1, "R2 reset status");
        bus_idle();

        // Restart with holdoff 5; clearing visible the next cycle
        bus_wr(0, 32'h0000_0005);
        bus_rd(0, 32'h8050_0005, '1, "R8 R1 clearing after write");
        bus_idle();
        trig_pulse(v);                       // R3: too early, ignored
        wait_cyc(2);
        bus_rd(0, 32'h0050_0005, '1, "R3 early trigger ignored");
        bus_idle();
        wait_cyc(40);
        bus_rd(0, 32'h1050_0005, '1, "R3 primed after fill");
        bus_idle();

        trig_pulse(v);
        wait_cyc(10);
        bus_rd(0, 32'h7050_0005, '1, "R4 R10 stopped and triggered");
        for (int k = 0; k < D; k++)
            bus_rd(1, v + 32'd5 - 32'd31 + 32'(k), '1, "R7 R4 readout holdoff 5");
        bus_rd(1, v + 32'd5 - 32'd31, '1, "R7 wrap to oldest");
        bus_wr(1, 32'hDEAD_BEEF);
        bus_rd(1, v + 32'd5 - 32'd30, '1, "R9 data write ignored");
        bus_idle();

        // Disabled trigger input
        bus_wr(0, 32'h0400_0000);
        bus_idle();
        wait_cyc(40);
        trig_pulse(v);
        wait_cyc(5);
        bus_rd(0, 32'h1650_0000, '1, "R5 disabled ignores trigger");
        bus_idle();

        // Holdoff zero
        bus_wr(0, 32'h0000_0000);
        bus_idle();
        wait_cyc(40);
        trig_pulse(v);
        wait_cyc(5);
        bus_rd(0, 32'h7250_0000, '1, "R2 R4 zero holdoff status");
        for (int k = 0; k < D; k++)
            bus_rd(1, v - 32'd31 + 32'(k), '1, "R4 holdoff 0 newest is trigger");
        bus_idle();

        // Manual force
        bus_wr(0, 32'h0800_0003);
        bus_idle();
        wait_cyc(45);
        bus_rd(0, 32'h7850_0003, '1, "R6 manual trigger stops");
        bus_rd(1, '0, '0, "R6 first word");
        @(negedge clk);
        x = bus_rdata;
        bus_cyc = 0; bus_stb = 0;
        for (int k = 1; k < D; k++)
            bus_rd(1, x + 32'(k), '1, "R6 R7 manual readout run");
        bus_idle();
        trig_pulse(v);
        wait_cyc(10);
        for (int k = 0; k < D; k++)
            bus_rd(1, x + 32'(k), '1, "R10 frozen second pass");
        bus_idle();
        wait_cyc(3);
        chk(q.size() == 0, "R9 all reads acknowledged", 32'(q.size()), 32'h0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired R9 actual=%0d expected=%0d", cyc_cnt, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule